// File: doc/BRIEF.md
# Latched Parallel-In Serial-Out Register

This block turns a parallel word into a serial bit stream. It has two stages. A holding register samples the parallel pins when its capture strobe fires. A separate shift register then takes that held word when the mode input asks for a load. Because of this split, the pins can be sampled at one instant and shifted out later, even while they keep changing.

In shift mode, each shift strobe moves the shift register one stage toward its last stage. The serial input enters the first stage. The last stage drives the serial output. An active-low output enable gates that output, so several of these blocks can share one SPI-style data line. Disabled blocks report their output as not driven. Both strobes are synchronous enables in a single clock domain. A synchronous active-low reset clears both registers.

Each cycle the control decodes the mode input and the shift strobe into one of three operations. OP_HOLD keeps the shift register unchanged. It is chosen when the block is in shift mode and the shift strobe is low. OP_LOAD copies the load word into the shift register. It is chosen whenever the mode input is low, whatever the shift strobe does. OP_SHIFT advances the register by one stage. It is chosen in shift mode when the shift strobe is high. A separate forward flag sets the load word. When the capture strobe is high in the same cycle, the load word comes from the pins; otherwise it comes from the holding register. There are no other states or transitions.

Top module: `piso_latched`

## Requirements
- R1: When `rst_n` is low at a clock edge, both the holding register and the shift register become all zeros. After that edge, `ser_q` reads 0.
- R2: When `cap_en` is high at a clock edge, the holding register takes `par_in`. This happens whatever `shift_mode` and `shf_en` are doing. When `cap_en` is low, the holding register keeps its value.
- R3: When `shift_mode` is 0 and `cap_en` is 0 at a clock edge, the shift register loads the holding register's contents. It never loads the live pins.
- R4: When `shift_mode` is 1 and `shf_en` is 1 at a clock edge, each stage k takes stage k-1, and stage 0 takes `ser_in`. Stage 0 is A, and stage W-1 is H.
- R5: When `shift_mode` is 1 and `shf_en` is 0, the shift register keeps its value.
- R6: When `shift_mode` is 0, a load happens even if `shf_en` is 1 in the same cycle. No shift takes place in that cycle.
- R7: When `cap_en` is high and `shift_mode` is 0 in the same cycle, the shift register receives that cycle's `par_in`. The holding register receives it too.
- R8: `ser_q` always equals stage H, which is the last stage (index W-1). Right after a load, `ser_q` is bit W-1 of the loaded word. After j further shifts, it is bit W-1-j. The word therefore leaves H first.
- R9: `ser_oe` equals the inverse of `oe_n`, so the output is driven only while `oe_n` is 0. Both registers keep loading and shifting while `oe_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| par_in | input | W | Parallel pins; bit 0 is stage A, bit W-1 is stage H |
| cap_en | input | 1 | Capture strobe for the holding register |
| shift_mode | input | 1 | 1 selects serial shifting, 0 selects a load from the holding stage |
| shf_en | input | 1 | Shift strobe, used in shift mode |
| ser_in | input | 1 | Serial input into stage A |
| oe_n | input | 1 | Output enable, active low |
| ser_q | output | 1 | Serial data, equal to stage H |
| ser_oe | output | 1 | High when `ser_q` drives the shared line; low means high impedance |

## Verification
The assertions check these rules on every cycle:
- A capture lands in the holding register.
- A shift moves every stage and brings in the serial input.
- An idle strobe holds the shift register.
- A load always wins over the shift strobe.
- A plain load takes the holding register's contents, and a load that coincides with a capture takes the pins.

Only the bench scenarios show the end-to-end behaviour. They check that a word captured earlier leaves H first, even while the pins take other values. They check that the serial input reappears at the output after a full register length. They also check that shifting continues unseen while the output is disabled, and that the reset state is visible on the output.

// File: rtl/piso_pkg.sv
package piso_pkg;

    // Operation applied to the shift register in a given cycle
    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_LOAD  = 2'd1,
        OP_SHIFT = 2'd2
    } piso_op_e;

endpackage

// File: rtl/piso_ctrl.sv
module piso_ctrl
    import piso_pkg::*;
(
    input  logic     shift_mode,
    input  logic     shf_en,
    input  logic     cap_en,
    output piso_op_e op,
    output logic     fwd
);

    // Decode of the mode input and the shift strobe; a load overrides the strobe
    always_comb begin
        unique case ({shift_mode, shf_en})
            2'b00:   op = OP_LOAD;
            2'b01:   op = OP_LOAD;   // R6: load wins over a coincident shift strobe
            2'b10:   op = OP_HOLD;
            2'b11:   op = OP_SHIFT;
            default: op = OP_HOLD;
        endcase
    end

    // A capture in the same cycle forwards the pins to the load path (R7)
    always_comb begin
        fwd = cap_en;
    end

endmodule

// File: rtl/piso_hold_reg.sv
module piso_hold_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cap_en,
    input  logic [W-1:0] par_in,
    output logic [W-1:0] hold_q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else if (cap_en) begin
            hold_q <= par_in;
        end
    end

    assert_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cap_en |=> hold_q == $past(par_in));

    assert_keep_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!cap_en && $past(rst_n)) |=> $stable(hold_q));

endmodule

// File: rtl/piso_shift_reg.sv
module piso_shift_reg
    import piso_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  piso_op_e     op,
    input  logic [W-1:0] load_word,
    input  logic         ser_in,
    output logic [W-1:0] stage_q
);

    logic [W-1:0] stage_d;

    // Stage 0 (A) takes the serial input; each later stage takes its neighbour
    genvar k;
    generate
        for (k = 0; k < W; k++) begin : g_stage
            if (k == 0) begin : g_first
                always_comb begin
                    unique case (op)
                        OP_LOAD:  stage_d[k] = load_word[k];
                        OP_SHIFT: stage_d[k] = ser_in;
                        default:  stage_d[k] = stage_q[k];
                    endcase
                end
            end else begin : g_rest
                always_comb begin
                    unique case (op)
                        OP_LOAD:  stage_d[k] = load_word[k];
                        OP_SHIFT: stage_d[k] = stage_q[k-1];
                        default:  stage_d[k] = stage_q[k];
                    endcase
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q <= stage_d;
        end
    end

    assert_shift_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_SHIFT) |=> stage_q == {$past(stage_q[W-2:0]), $past(ser_in)});

    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_HOLD && $past(rst_n)) |=> $stable(stage_q));

    assert_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_LOAD) |=> stage_q == $past(load_word));

endmodule

// File: rtl/piso_out_stage.sv
module piso_out_stage (
    input  logic oe_n,
    input  logic stage_h,
    output logic ser_q,
    output logic ser_oe
);

    always_comb begin
        ser_q  = stage_h;
        ser_oe = ~oe_n;
    end

endmodule

// File: rtl/piso_latched.sv
module piso_latched
    import piso_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] par_in,
    input  logic         cap_en,
    input  logic         shift_mode,
    input  logic         shf_en,
    input  logic         ser_in,
    input  logic         oe_n,
    output logic         ser_q,
    output logic         ser_oe
);

    localparam int HI = W - 1;

    piso_op_e     op;
    logic         fwd;
    logic [W-1:0] hold_q;
    logic [W-1:0] load_word;
    logic [W-1:0] stage_q;

    piso_ctrl u_ctrl (
        .shift_mode (shift_mode),
        .shf_en     (shf_en),
        .cap_en     (cap_en),
        .op         (op),
        .fwd        (fwd)
    );

    piso_hold_reg #(.W(W)) u_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .cap_en (cap_en),
        .par_in (par_in),
        .hold_q (hold_q)
    );

    // Load source: pins when captured this cycle, else the held word
    always_comb begin
        load_word = fwd ? par_in : hold_q;
    end

    piso_shift_reg #(.W(W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .op        (op),
        .load_word (load_word),
        .ser_in    (ser_in),
        .stage_q   (stage_q)
    );

    piso_out_stage u_out (
        .oe_n    (oe_n),
        .stage_h (stage_q[HI]),
        .ser_q   (ser_q),
        .ser_oe  (ser_oe)
    );

    assert_forward_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_en && !shift_mode) |=> stage_q == $past(par_in));

    assert_plain_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!cap_en && !shift_mode) |=> stage_q == $past(hold_q));

    assert_load_priority_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!shift_mode && shf_en && !cap_en) |=> stage_q == $past(hold_q));

    assert_out_h_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_mode && shf_en) |=> ser_q == $past(stage_q[HI-1]));

endmodule

// File: tb/piso_latched_tb.sv
module piso_latched_tb_top;

    localparam int W   = 8;
    localparam int PER = 10;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [W-1:0] par_in;
    logic         cap_en, shift_mode, shf_en, ser_in, oe_n;
    logic         ser_q, ser_oe;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #(PER/2) clk = ~clk;

    piso_latched #(.W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .par_in(par_in), .cap_en(cap_en),
        .shift_mode(shift_mode), .shf_en(shf_en), .ser_in(ser_in),
        .oe_n(oe_n), .ser_q(ser_q), .ser_oe(ser_oe)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // one clock edge, then settle away from it
    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        cap_en = 0; shift_mode = 1; shf_en = 0; ser_in = 0;
    endtask

    // Shift out W bits, expecting word H first; pins wander meanwhile
    task automatic read_word(input logic [W-1:0] exp, input string tag);
        for (int j = 0; j < W; j++) begin
            chk(ser_q == exp[W-1-j], tag, ser_q, exp[W-1-j]);
            par_in = W'($urandom);
            shift_mode = 1; shf_en = 1; cap_en = 0;
            step();
        end
        shf_en = 0;
    endtask

    task automatic t_reset();
        rst_n = 0; oe_n = 0; par_in = '1; idle();
        cap_en = 1;
        step(); step();
        chk(ser_q == 0, "R1 reset clears shift", ser_q, 0);
        rst_n = 1; cap_en = 0; shift_mode = 0;
        step();
        chk(ser_q == 0, "R1 reset clears hold", ser_q, 0);
        idle();
    endtask

    task automatic t_latch_then_shift();
        for (int n = 0; n < 4; n++) begin
            logic [W-1:0] w;
            w = W'($urandom);
            if (n == 0) w = 8'hA5;
            par_in = w; cap_en = 1; step();
            cap_en = 0; par_in = ~w; step();          // R2: pins changed after capture
            shift_mode = 0; step();                   // R3: load from holding register
            chk(ser_q == w[W-1], "R3 load takes held word", ser_q, w[W-1]);
            read_word(w, "R8 H-first matches latched word");
        end
    endtask

    task automatic t_serial_in();
        logic [W-1:0] s;
        s = 8'b1101_0010;
        par_in = '0; cap_en = 1; shift_mode = 0; step();
        cap_en = 0;
        for (int j = 0; j < W; j++) begin
            ser_in = s[W-1-j]; shift_mode = 1; shf_en = 1; step();
        end
        shf_en = 0;
        read_word(s, "R4 serial input reaches H");
    endtask

    task automatic t_hold();
        par_in = 8'h80; cap_en = 1; shift_mode = 0; step();
        cap_en = 0; shift_mode = 1; shf_en = 0;
        for (int j = 0; j < 5; j++) step();
        chk(ser_q == 1, "R5 no strobe keeps H", ser_q, 1);
        shf_en = 1; step(); shf_en = 0;
        chk(ser_q == 0, "R5 one strobe moves", ser_q, 0);
    endtask

    task automatic t_priority();
        par_in = 8'h3C; cap_en = 1; shift_mode = 1; step();  // hold = 3C
        cap_en = 0; par_in = 8'hFF;
        shift_mode = 0; shf_en = 1; step();                   // load wins
        shift_mode = 1; shf_en = 0;
        chk(ser_q == 0, "R6 load over shift H", ser_q, 0);
        read_word(8'h3C, "R6 load over shift word");
    endtask

    task automatic t_forward();
        par_in = 8'h00; cap_en = 1; shift_mode = 1; step();   // hold = 00
        par_in = 8'hC3; cap_en = 1; shift_mode = 0; step();   // capture+load
        cap_en = 0; shift_mode = 1; par_in = 8'h00;
        chk(ser_q == 1, "R7 forwarded word H", ser_q, 1);
        read_word(8'hC3, "R7 forwarded word");
        shift_mode = 0; step(); shift_mode = 1;               // hold also got C3
        read_word(8'hC3, "R7 hold also captured");
    endtask

    task automatic t_oe();
        par_in = 8'hF0; cap_en = 1; shift_mode = 0; step();
        cap_en = 0; shift_mode = 1;
        oe_n = 1; #1;
        chk(ser_oe == 0, "R9 disabled", ser_oe, 0);
        shf_en = 1; ser_in = 0;
        for (int j = 0; j < 4; j++) step();                  // shifting unseen
        shf_en = 0;
        oe_n = 0; #1;
        chk(ser_oe == 1, "R9 enabled", ser_oe, 1);
        chk(ser_q == 0, "R9 contents moved while disabled", ser_q, 0);
        read_word(8'h00, "R9 remaining bits");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #1;
        t_reset();
        t_latch_then_shift();
        t_serial_in();
        t_hold();
        t_priority();
        t_forward();
        t_oe();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule